// File: doc/BRIEF.md
# Endpoint Buffer Register Access Controller

This block connects a processor's register port to the packet buffer RAM of a multi-endpoint USB device. Software picks a logical endpoint and a direction through a control register, then moves a packet one 32-bit word at a time through a single data register per direction. The block computes the buffer addresses, tracks how many bytes are left, and raises a sticky end-of-packet flag for each direction.

In receive mode the block first loads the packet's byte count, which sits in word 0 of the endpoint's receive region. It then prefetches the first payload word, so that the first software read returns data at once. Each later read fetches the next word. The read that consumes the final byte drops receive mode by itself.

In transmit mode software programs a byte count first. Each data write goes straight to the buffer RAM in the same cycle and lowers the count by four. The write that uses up the count ends transmit mode.

Top module: `epbuf_access`

## Requirements
- R1: Register offsets on `reg_addr` are: 0 control, 1 receive length, 2 receive data, 3 transmit length, 4 transmit data, 5 status. The control register has bit 0 = receive enable, bit 1 = transmit enable and bits 5:2 = endpoint number. It reads back these fields and resets to 0.
- R2: Writing control with bit 0 set starts receive mode. The block reads buffer word `ep*32` and places its bits 9:0 in the receive length register. It then reads word `ep*32+1` into the receive data register. The word is ready 3 cycles after the control write, which is shown by status bit 2.
- R3: In receive mode, a read of receive data while a word is ready returns that word and starts a fetch of the next buffer word. The next word is ready 2 cycles after the read.
- R4: The receive data read that covers the last byte of the packet clears receive enable and sets status bit 0. A packet length of zero ends receive mode right after the length fetch and also sets status bit 0.
- R5: A receive data read while no word is ready (mode off or a fetch in progress) returns 0 and does not advance. Entering receive mode again restarts at the first payload word.
- R6: The transmit length register (bits 9:0) resets to 0 and reads back what remains. Each accepted transmit data write lowers it by 4 and stops at 0 without wrapping.
- R7: In transmit mode, each transmit data write drives `buf_wr` in the same cycle. The address is `(16+ep)*32 + n`, where n counts accepted writes from 0 after mode entry, and the data is the written word.
- R8: The write that brings the remaining length to 0 clears transmit enable and sets status bit 1. Entering transmit mode while the length is 0 sets status bit 1 at once and does not enable transmit mode.
- R9: A transmit data write while transmit mode is off does not write the buffer and does not change the transmit length.
- R10: A control write with both enable bits set starts receive mode only. Transmit enable reads back as 0 and transmit data writes are ignored.
- R11: Status bits 0 and 1 are cleared by writing 1 to them. Writing 0 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has side effects on receive data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| buf_addr | output | 10 | Buffer RAM word address |
| buf_rd | output | 1 | Buffer read request; data expected on the next cycle |
| buf_rdata | input | 32 | Buffer read data |
| buf_wr | output | 1 | Buffer write strobe |
| buf_wdata | output | 32 | Buffer write data |

## Verification
The bench builds the block with its default parameters: 16 endpoints, 32-word regions and a 10-bit length. With 16 endpoints the power-of-two address variant is the one elaborated, so the exact buffer addresses of both regions can be checked. The 10-bit length allows byte counts that are not multiples of four, which test the saturating countdown and the partial final word. A behavioural model of the transmit path predicts `buf_wr` and `buf_addr` on every clock. Scripted sequences cover the prefetch timing, zero-length packets in both directions, the priority between the two enable bits, and the clear-by-one status bits.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;

   localparam int REG_AW = 3;

   localparam logic [REG_AW-1:0] RA_CTRL   = 3'd0;
   localparam logic [REG_AW-1:0] RA_RXLEN  = 3'd1;
   localparam logic [REG_AW-1:0] RA_RXDATA = 3'd2;
   localparam logic [REG_AW-1:0] RA_TXLEN  = 3'd3;
   localparam logic [REG_AW-1:0] RA_TXDATA = 3'd4;
   localparam logic [REG_AW-1:0] RA_STATUS = 3'd5;

   localparam int CT_RD    = 0;
   localparam int CT_WR    = 1;
   localparam int CT_EP_LO = 2;

   localparam int ST_RX_EOP = 0;
   localparam int ST_TX_EOP = 1;
   localparam int ST_RX_RDY = 2;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_LEN_REQ,
      RX_LEN_WAIT,
      RX_DATA_WAIT,
      RX_READY,
      RX_NEXT_REQ
   } rx_state_e;

endpackage

// File: rtl/epbuf_addr_map.sv
module epbuf_addr_map #(
   parameter int NUM_EP = 16,
   parameter int EP_W   = 4,
   parameter int WORD_W = 5,
   parameter int AW     = 10
) (
   input  logic              dir,
   input  logic [EP_W-1:0]   ep,
   input  logic [WORD_W-1:0] word,
   output logic [AW-1:0]     addr
);
   localparam int WPE  = 1 << WORD_W;
   localparam bit POW2 = (NUM_EP & (NUM_EP - 1)) == 0;

   generate
      if (NUM_EP < 2 || NUM_EP > (1 << EP_W)) begin : g_bad_ep
         $error("epbuf_addr_map: NUM_EP must be within 2 .. 2**EP_W");
      end
      if (POW2) begin : g_concat
         localparam int EPB = $clog2(NUM_EP);
         if (1 + EPB + WORD_W != AW) begin : g_bad_aw
            $error("epbuf_addr_map: AW mismatch");
         end
         assign addr = {dir, ep[EPB-1:0], word};
      end else begin : g_arith
         assign addr = AW'((32'(dir) * 32'(NUM_EP) + 32'(ep)) * 32'(WPE) + 32'(word));
      end
   endgenerate

endmodule

// File: rtl/epbuf_rx_engine.sv
module epbuf_rx_engine
   import epbuf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 10,
   parameter int WORD_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic              consume,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              active,
   output logic              mem_req,
   output logic              len_phase,
   output logic [WORD_W-1:0] word_idx,
   output logic [LEN_W-1:0]  rx_len,
   output logic [DATA_W-1:0] rx_word,
   output logic              word_ready,
   output logic              eop_pulse
);
   localparam int STEP = DATA_W / 8;

   rx_state_e        state;
   logic [LEN_W-1:0] left;
   logic [LEN_W-1:0] fetched_len;
   logic             last_word;
   logic             take;

   assign fetched_len = mem_rdata[LEN_W-1:0];
   assign last_word   = left <= LEN_W'(STEP);
   assign active      = state != RX_IDLE;
   assign word_ready  = state == RX_READY;
   assign len_phase   = state == RX_LEN_REQ;
   assign take        = consume && word_ready;
   assign mem_req     = (state == RX_LEN_REQ) || (state == RX_NEXT_REQ) ||
                        ((state == RX_LEN_WAIT) && (fetched_len != '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         left      <= '0;
         word_idx  <= '0;
         rx_len    <= '0;
         rx_word   <= '0;
         eop_pulse <= 1'b0;
      end else begin
         eop_pulse <= 1'b0;
         if (start) begin
            state    <= RX_LEN_REQ;
            word_idx <= '0;
         end else if (stop) begin
            state <= RX_IDLE;
         end else begin
            case (state)
               RX_LEN_REQ: state <= RX_LEN_WAIT;
               RX_LEN_WAIT: begin
                  rx_len <= fetched_len;
                  left   <= fetched_len;
                  if (fetched_len == '0) begin
                     state     <= RX_IDLE;
                     eop_pulse <= 1'b1;
                  end else begin
                     state <= RX_DATA_WAIT;
                  end
               end
               RX_DATA_WAIT: begin
                  rx_word <= mem_rdata;
                  state   <= RX_READY;
               end
               RX_READY: begin
                  if (take) begin
                     if (last_word) begin
                        state     <= RX_IDLE;
                        eop_pulse <= 1'b1;
                     end else begin
                        left     <= left - LEN_W'(STEP);
                        word_idx <= word_idx + 1'b1;
                        state    <= RX_NEXT_REQ;
                     end
                  end
               end
               RX_NEXT_REQ: state <= RX_DATA_WAIT;
               default:     state <= RX_IDLE;
            endcase
         end
      end
   end

   // R4: the end-of-packet pulse only appears once receive mode has closed
   a_r4_eop_closes: assert property (@(posedge clk) disable iff (!rst_n)
      eop_pulse |-> !active);

   // R5: the word index moves only on a consumed word or on mode entry
   a_r5_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!consume && !start) |=> $stable(word_idx));

   // R3: a ready word always follows a data fetch
   a_r3_ready_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_ready) |-> $past(state == RX_DATA_WAIT));

endmodule

// File: rtl/epbuf_tx_engine.sv
module epbuf_tx_engine #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 10,
   parameter int WORD_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic              len_wr,
   input  logic [LEN_W-1:0]  len_val,
   input  logic              data_wr,
   output logic              active,
   output logic [LEN_W-1:0]  tx_len,
   output logic [WORD_W-1:0] word_idx,
   output logic              mem_wr,
   output logic              eop_pulse
);
   localparam int STEP = DATA_W / 8;

   logic             final_word;
   logic [LEN_W-1:0] next_len;

   assign mem_wr     = data_wr && active;
   assign final_word = tx_len <= LEN_W'(STEP);
   assign next_len   = final_word ? '0 : tx_len - LEN_W'(STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         tx_len    <= '0;
         word_idx  <= '0;
         eop_pulse <= 1'b0;
      end else begin
         eop_pulse <= 1'b0;
         if (len_wr) begin
            tx_len <= len_val;
         end
         if (start) begin
            word_idx <= '0;
            if (tx_len == '0) begin
               active    <= 1'b0;
               eop_pulse <= 1'b1;
            end else begin
               active <= 1'b1;
            end
         end else if (stop) begin
            active <= 1'b0;
         end else if (mem_wr) begin
            tx_len   <= next_len;
            word_idx <= word_idx + 1'b1;
            if (final_word) begin
               active    <= 1'b0;
               eop_pulse <= 1'b1;
            end
         end
      end
   end

   // R6: no buffer write is issued against an exhausted count
   a_r6_no_write_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> tx_len != '0);

   // R6: without a software load the count never grows
   a_r6_len_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
      !len_wr |=> tx_len <= $past(tx_len));

   // R9: outside transmit mode the count is only changed by software
   a_r9_idle_keeps_len: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !len_wr) |=> $stable(tx_len));

endmodule

// File: rtl/epbuf_access.sv
module epbuf_access
   import epbuf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 10,
   parameter int EP_W   = 4,
   parameter int NUM_EP = 16,
   parameter int WORD_W = 5,
   localparam int BUF_AW = $clog2(2 * NUM_EP) + WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [BUF_AW-1:0] buf_addr,
   output logic              buf_rd,
   input  logic [DATA_W-1:0] buf_rdata,
   output logic              buf_wr,
   output logic [DATA_W-1:0] buf_wdata
);
   localparam int CTRL_W = CT_EP_LO + EP_W;

   generate
      if (DATA_W != 32) begin : g_bad_dw
         $error("epbuf_access: the countdown step assumes 32-bit words");
      end
      if (LEN_W < 3 || LEN_W > DATA_W) begin : g_bad_lw
         $error("epbuf_access: LEN_W out of range");
      end
      if (CTRL_W > DATA_W || WORD_W < 1) begin : g_bad_cw
         $error("epbuf_access: control or word width out of range");
      end
   endgenerate

   logic [EP_W-1:0] ep_q;
   logic            ctrl_wr, stat_wr, rd_bit, wr_bit;
   logic            rx_start, rx_stop, tx_start, tx_stop;
   logic            rx_active, rx_req, rx_len_phase, rx_ready, rx_eop;
   logic            tx_active, tx_mem_wr, tx_eop;
   logic            rx_eop_q, tx_eop_q;
   logic [WORD_W-1:0] rx_idx, tx_idx, map_word;
   logic [LEN_W-1:0]  rx_len, tx_len;
   logic [DATA_W-1:0] rx_word;

   assign ctrl_wr  = reg_wr && (reg_addr == RA_CTRL);
   assign stat_wr  = reg_wr && (reg_addr == RA_STATUS);
   assign rd_bit   = reg_wdata[CT_RD];
   assign wr_bit   = reg_wdata[CT_WR];
   assign rx_start = ctrl_wr && rd_bit;
   assign rx_stop  = ctrl_wr && !rd_bit;
   assign tx_start = ctrl_wr && wr_bit && !rd_bit;
   assign tx_stop  = ctrl_wr && !(wr_bit && !rd_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ep_q <= '0;
      end else if (ctrl_wr) begin
         ep_q <= reg_wdata[CTRL_W-1:CT_EP_LO];
      end
   end

   epbuf_rx_engine #(
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W),
      .WORD_W (WORD_W)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (rx_start),
      .stop       (rx_stop),
      .consume    (reg_rd && (reg_addr == RA_RXDATA)),
      .mem_rdata  (buf_rdata),
      .active     (rx_active),
      .mem_req    (rx_req),
      .len_phase  (rx_len_phase),
      .word_idx   (rx_idx),
      .rx_len     (rx_len),
      .rx_word    (rx_word),
      .word_ready (rx_ready),
      .eop_pulse  (rx_eop)
   );

   epbuf_tx_engine #(
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W),
      .WORD_W (WORD_W)
   ) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (tx_start),
      .stop      (tx_stop),
      .len_wr    (reg_wr && (reg_addr == RA_TXLEN)),
      .len_val   (reg_wdata[LEN_W-1:0]),
      .data_wr   (reg_wr && (reg_addr == RA_TXDATA)),
      .active    (tx_active),
      .tx_len    (tx_len),
      .word_idx  (tx_idx),
      .mem_wr    (tx_mem_wr),
      .eop_pulse (tx_eop)
   );

   // receive payload sits one word above the length word
   assign map_word = tx_mem_wr    ? tx_idx :
                     rx_len_phase ? '0     : rx_idx + 1'b1;

   epbuf_addr_map #(
      .NUM_EP (NUM_EP),
      .EP_W   (EP_W),
      .WORD_W (WORD_W),
      .AW     (BUF_AW)
   ) u_map (
      .dir  (tx_mem_wr),
      .ep   (ep_q),
      .word (map_word),
      .addr (buf_addr)
   );

   assign buf_rd    = rx_req;
   assign buf_wr    = tx_mem_wr;
   assign buf_wdata = reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_eop_q <= 1'b0;
         tx_eop_q <= 1'b0;
      end else begin
         if (rx_eop) begin
            rx_eop_q <= 1'b1;
         end else if (stat_wr && reg_wdata[ST_RX_EOP]) begin
            rx_eop_q <= 1'b0;
         end
         if (tx_eop) begin
            tx_eop_q <= 1'b1;
         end else if (stat_wr && reg_wdata[ST_TX_EOP]) begin
            tx_eop_q <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL: begin
            reg_rdata[CT_RD]                = rx_active;
            reg_rdata[CT_WR]                = tx_active;
            reg_rdata[CTRL_W-1:CT_EP_LO]    = ep_q;
         end
         RA_RXLEN:  reg_rdata[LEN_W-1:0] = rx_len;
         RA_RXDATA: reg_rdata            = rx_ready ? rx_word : '0;
         RA_TXLEN:  reg_rdata[LEN_W-1:0] = tx_len;
         RA_STATUS: begin
            reg_rdata[ST_RX_EOP] = rx_eop_q;
            reg_rdata[ST_TX_EOP] = tx_eop_q;
            reg_rdata[ST_RX_RDY] = rx_ready;
         end
         default: reg_rdata = '0;
      endcase
   end

   // R10: the two directions are never active together
   a_r10_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_active && tx_active));

   // R7: buffer port never reads and writes in one cycle
   a_r7_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(buf_rd && buf_wr));

   // R11: a set flag stays set unless software writes one to it
   a_r11_rx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_eop_q && !(stat_wr && reg_wdata[ST_RX_EOP])) |=> rx_eop_q);

   a_r11_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_eop_q && !(stat_wr && reg_wdata[ST_TX_EOP])) |=> tx_eop_q);

endmodule

// File: tb/sim_epbuf_access.sv
module sim_epbuf_access;
   localparam int CLK_PERIOD = 10;
   localparam int Q = CLK_PERIOD / 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [9:0]  buf_addr;
   logic        buf_rd;
   logic [31:0] buf_rdata = '0;
   logic        buf_wr;
   logic [31:0] buf_wdata;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [31:0] mem [1024];

   // behavioural transmit model
   bit       m_wr_en = 1'b0;
   int       m_tx_len = 0;
   int       m_tx_idx = 0;
   int       m_ep = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   epbuf_access u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .buf_addr  (buf_addr),
      .buf_rd    (buf_rd),
      .buf_rdata (buf_rdata),
      .buf_wr    (buf_wr),
      .buf_wdata (buf_wdata)
   );

   always @(posedge clk) begin
      if (buf_rd) buf_rdata <= mem[buf_addr];
      if (buf_wr) mem[buf_addr] <= buf_wdata;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-clock comparison of the buffer write port (R7, R9, R10)
   always begin
      @(negedge clk);
      #Q;
      if (rst_n && !done) begin
         bit exp_wr;
         exp_wr = reg_wr && (reg_addr == 3'd4) && m_wr_en;
         check("R7 buf_wr", {31'd0, buf_wr}, {31'd0, exp_wr});
         if (exp_wr && buf_wr) begin
            check("R7 buf_addr", {22'd0, buf_addr}, 32'((16 + m_ep) * 32 + m_tx_idx));
            check("R7 buf_wdata", buf_wdata, reg_wdata);
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(posedge clk);
      case (a)
         3'd0: begin
            m_ep     = int'(d[5:2]);
            m_tx_idx = 0;
            m_wr_en  = d[1] && !d[0] && (m_tx_len != 0);
         end
         3'd3: m_tx_len = int'(d[9:0]);
         3'd4: if (m_wr_en) begin
            if (m_tx_len <= 4) begin
               m_tx_len = 0;
               m_wr_en  = 1'b0;
            end else begin
               m_tx_len = m_tx_len - 4;
            end
            m_tx_idx++;
         end
         default: ;
      endcase
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      reg_addr = a;
      reg_rd   = 1'b1;
      #1 v = reg_rdata;
      @(posedge clk);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      mem[96]  = 32'd10;
      mem[97]  = 32'hA1A1_0001;
      mem[98]  = 32'hB2B2_0002;
      mem[99]  = 32'hC3C3_0003;
      mem[224] = 32'd0;
      mem[128] = 32'd4;
      mem[129] = 32'hE5E5_0005;

      idle(3);
      rst_n = 1'b1;
      idle(1);

      // reset state
      rd_chk(3'd0, 32'h0, "R1 ctrl reset");
      rd_chk(3'd3, 32'h0, "R6 txlen reset");
      rd_chk(3'd5, 32'h0, "R11 status reset");
      rd_chk(3'd2, 32'h0, "R5 rxdata while off");

      // R1 field readback
      wr(3'd0, 32'h14);
      rd_chk(3'd0, 32'h14, "R1 ctrl endpoint readback");

      // R2 receive entry on endpoint 3
      wr(3'd0, 32'h0D);
      idle(4);
      rd_chk(3'd1, 32'd10, "R2 rx length loaded");
      rd_chk(3'd5, 32'h4, "R2 word ready flag");
      rd_chk(3'd2, 32'hA1A1_0001, "R2 first word prefetched");
      idle(3);
      rd_chk(3'd2, 32'hB2B2_0002, "R3 second word");
      rd_chk(3'd0, 32'h0D, "R3 read mode still on");
      idle(3);
      rd_chk(3'd2, 32'hC3C3_0003, "R3 third word");
      rd_chk(3'd0, 32'h0C, "R4 read enable cleared");
      rd_chk(3'd5, 32'h1, "R4 rx end flag");
      rd_chk(3'd2, 32'h0, "R5 rxdata after end");

      // R5 re-entry restarts
      wr(3'd0, 32'h0D);
      rd_chk(3'd2, 32'h0, "R5 rxdata during fetch");
      idle(4);
      rd_chk(3'd2, 32'hA1A1_0001, "R5 restart at first word");
      wr(3'd0, 32'h0C);
      rd_chk(3'd5, 32'h1, "R11 flag kept on stop");

      // R11 write-one-to-clear
      wr(3'd5, 32'h2);
      rd_chk(3'd5, 32'h1, "R11 zero write no effect");
      wr(3'd5, 32'h1);
      rd_chk(3'd5, 32'h0, "R11 cleared by one");

      // R4 zero-length receive on endpoint 7
      wr(3'd0, 32'h1D);
      idle(4);
      rd_chk(3'd0, 32'h1C, "R4 zero length ends read");
      rd_chk(3'd5, 32'h1, "R4 zero length flag");
      wr(3'd5, 32'h1);

      // R6/R7/R8 transmit on endpoint 2, 10 bytes
      wr(3'd3, 32'd10);
      wr(3'd0, 32'h0A);
      rd_chk(3'd0, 32'h0A, "R8 write mode on");
      wr(3'd4, 32'hD0D0_0000);
      rd_chk(3'd3, 32'd6, "R6 length after one write");
      wr(3'd4, 32'hD1D1_0001);
      rd_chk(3'd3, 32'd2, "R6 length after two writes");
      wr(3'd4, 32'hD2D2_0002);
      rd_chk(3'd3, 32'd0, "R6 partial word saturates");
      rd_chk(3'd0, 32'h08, "R8 write enable cleared");
      rd_chk(3'd5, 32'h2, "R8 tx end flag");
      check("R7 mem word 0", mem[576], 32'hD0D0_0000);
      check("R7 mem word 1", mem[577], 32'hD1D1_0001);
      check("R7 mem word 2", mem[578], 32'hD2D2_0002);

      // R9 write with transmit off
      wr(3'd4, 32'hDEAD_BEEF);
      check("R9 no buffer write", mem[579], 32'h0);
      rd_chk(3'd3, 32'd0, "R9 length unchanged");
      wr(3'd5, 32'h2);
      rd_chk(3'd5, 32'h0, "R11 tx flag cleared");

      // R8 zero-length transmit entry
      wr(3'd0, 32'h0A);
      rd_chk(3'd0, 32'h08, "R8 zero length no write mode");
      rd_chk(3'd5, 32'h2, "R8 zero length flag");
      wr(3'd5, 32'h2);

      // R10 both enables on endpoint 4
      wr(3'd3, 32'd8);
      wr(3'd0, 32'h13);
      rd_chk(3'd0, 32'h11, "R10 read wins");
      wr(3'd4, 32'h5555_AAAA);
      rd_chk(3'd3, 32'd8, "R10 tx write ignored");
      check("R10 no IN write", mem[(16 + 4) * 32], 32'h0);
      idle(4);
      rd_chk(3'd2, 32'hE5E5_0005, "R10 read path works");
      rd_chk(3'd0, 32'h10, "R4 single word ends read");
      wr(3'd5, 32'h3);

      // R6 saturation with 6 bytes
      wr(3'd3, 32'd6);
      wr(3'd0, 32'h0A);
      wr(3'd4, 32'h1111_0000);
      rd_chk(3'd3, 32'd2, "R6 six minus four");
      wr(3'd4, 32'h2222_0000);
      rd_chk(3'd3, 32'd0, "R6 floor at zero");
      rd_chk(3'd5, 32'h2, "R8 end after partial word");
      check("R7 restart index", mem[576], 32'h1111_0000);

      idle(2);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule